// File: doc/BRIEF.md
# Audio Ring-Buffer DMA Channel

One channel of an audio DMA engine. It moves 32-bit sample words between a circular buffer in memory and one serial slot of an audio codec. Software programs three registers: a base register, a format register and a control register. The control register sets a log2 buffer-size code, a log2 fragment code and two ring pointers counted in 32-byte chunks. The direction bit decides which pointer the hardware advances and which one software owns.

For playback (output), the channel fetches one word ahead from memory and hands it to the codec on each slot tick. If no fresh word is ready it repeats the last sample, and it plays zero while idle. For capture (input), it latches the codec word on each slot tick and writes it to memory. The hardware pointer never overtakes the software pointer. A one-cycle fragment interrupt marks each fragment boundary the hardware pointer reaches.

Top module: `audio_ring_dma`

## Requirements
- R1: After reset `ctl_rd_o`, `mem_req_o`, `smp_o` and `frag_irq_o` are all zero.
- R2: The memory address is `{base, 8'h00}` plus the byte offset into the ring, so address bit 37 follows base bit 29. The offset advances by 4 bytes on each acknowledged word. A request stays raised until it is acknowledged.
- R3: With the size code s in control bits [4:2] (valid 2..7), the ring holds 2^(s+6) bytes and the offset wraps to 0 at that length.
- R4: The hardware pointer equals the byte offset divided by 32. Control bits [15:8] and [23:16] hold the write and read pointers. Format bit 0 selects output (1) or input (0). On output the hardware owns the read pointer; on input it owns the write pointer. Readback shows the hardware pointer in the field it owns and the last written value in the other field.
- R5: An output channel fetches only while the hardware chunk differs from the software pointer, masked to the ring size. An input channel accepts a slot word only while the chunk after the hardware chunk differs from the software pointer; otherwise the tick is dropped.
- R6: With the fragment code t in control bits [7:5], `frag_irq_o` pulses for one cycle after each word that leaves the offset at a multiple of 2^(13-t) bytes.
- R7: A control write that sets enable (bit 1) on a disabled channel restarts the offset at 0.
- R8: A control write with bit 0 set clears all control fields and the hardware pointer and drops any transfer.
- R9: A control write that clears enable while both pointer fields are zero zeroes the hardware pointer. Clearing enable with a nonzero pointer field stops transfers but keeps the pointer.
- R10: On an output slot tick, `smp_o` takes the staged word one cycle later. If no word is staged (underflow), `smp_o` repeats its last value.
- R11: While an output channel is disabled, `smp_o` is zero, including after a channel that was playing is shut down.
- R12: An input channel latches `smp_i` on a slot tick. It then issues a write (`mem_we_o` = 1) with that word at the current offset.
- R13: Format bit 1 drives `stereo_o`, bit 2 drives `wide_o`, and bits [5:3] drive `slot_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 base, 1 format, 2 control |
| reg_wdata_i | input | 32 | Register write data |
| ctl_rd_o | output | 32 | Control readback with the live hardware pointer |
| slot_o | output | 3 | Codec slot number |
| stereo_o | output | 1 | Stereo frame format |
| wide_o | output | 1 | 16-bit sample format |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 40 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with ack |
| mem_ack_i | input | 1 | Memory acknowledge |
| slot_tick_i | input | 1 | Codec slot strobe |
| smp_i | input | 32 | Captured codec word |
| smp_o | output | 32 | Word played to the codec |
| frag_irq_o | output | 1 | Fragment interrupt pulse |

## Verification
The assertions rely on three things software is expected to do:
- write the format register and the size and fragment codes only while the channel is disabled;
- use size codes in 2..7;
- acknowledge memory only while a request is raised.

The stimulus follows all three. It reprograms format and codes only after a reset-bit or disable write, and its memory responder acknowledges once on the falling edge after each request. Slot ticks are spaced widely enough that each staged word is fetched or written before the next tick.

// File: rtl/audio_dma_pkg.sv
`timescale 1ns/1ps
package audio_dma_pkg;
  localparam int PTR_W    = 8;
  localparam int CHUNK_LG = 5;
  localparam int WORD_LG  = 2;
  localparam int BASE_W   = 32;
  localparam int DATA_W   = 32;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_FMT  = 2'd1,
    SEL_CTL  = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic       dir_out;
    logic       stereo;
    logic       wide;
    logic [2:0] slot;
  } fmt_t;

  typedef struct packed {
    logic             en;
    logic [2:0]       size;
    logic [2:0]       tmask;
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] rptr;
  } ctl_t;
endpackage

// File: rtl/audio_dma_regs.sv
`timescale 1ns/1ps
module audio_dma_regs
  import audio_dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [31:0]       wdata_i,
  output logic [BASE_W-1:0] base_o,
  output fmt_t              fmt_o,
  output ctl_t              ctl_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              clr_o
);
  localparam int WP_LO = 8;
  localparam int RP_LO = WP_LO + PTR_W;

  logic  wr_ctl;
  logic  ptrs_zero;
  ctl_t  ctl_q;

  assign wr_ctl    = we_i && (sel_i == SEL_CTL);
  assign ptrs_zero = (wdata_i[RP_LO+PTR_W-1:WP_LO] == '0);
  // enable rising restarts; clearing enable always stops
  assign start_o   = wr_ctl && !wdata_i[0] && wdata_i[1] && !ctl_q.en;
  assign stop_o    = wr_ctl && (wdata_i[0] || !wdata_i[1]);
  assign clr_o     = wr_ctl && (wdata_i[0] || (!wdata_i[1] && ptrs_zero));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      fmt_o  <= '0;
      ctl_q  <= '0;
    end else if (we_i) begin
      case (sel_i)
        SEL_BASE: base_o <= wdata_i[BASE_W-1:0];
        SEL_FMT:  fmt_o  <= '{dir_out: wdata_i[0], stereo: wdata_i[1],
                              wide: wdata_i[2], slot: wdata_i[5:3]};
        SEL_CTL: begin
          if (wdata_i[0]) ctl_q <= '0;
          else ctl_q <= '{en: wdata_i[1], size: wdata_i[4:2], tmask: wdata_i[7:5],
                          wptr: wdata_i[WP_LO+PTR_W-1:WP_LO],
                          rptr: wdata_i[RP_LO+PTR_W-1:RP_LO]};
        end
        default: ;
      endcase
    end
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/audio_dma_ring.sv
`timescale 1ns/1ps
module audio_dma_ring
  import audio_dma_pkg::*;
#(
  parameter int SIZE_BIAS = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      clr_i,
  input  logic                      step_i,
  input  logic                      dir_out_i,
  input  logic [2:0]                size_i,
  input  logic [2:0]                tmask_i,
  input  logic [PTR_W-1:0]          sw_ptr_i,
  output logic [PTR_W+CHUNK_LG-1:0] off_o,
  output logic [PTR_W-1:0]          hw_ptr_o,
  output logic                      may_go_o,
  output logic                      frag_o
);
  localparam int OFF_W = PTR_W + CHUNK_LG;
  localparam int SH_W  = $clog2(OFF_W + 1);

  logic [OFF_W-1:0] off_q, off_nxt, buf_mask, frag_mask;
  logic [SH_W-1:0]  buf_sh;
  logic [PTR_W-1:0] chunk_mask, sw_m, nxt_chunk;
  logic             frag_q;

  assign buf_sh     = SH_W'(OFF_W - SIZE_BIAS) - SH_W'(size_i);
  assign buf_mask   = {OFF_W{1'b1}} >> buf_sh;
  assign frag_mask  = {OFF_W{1'b1}} >> tmask_i;
  assign off_nxt    = (off_q + OFF_W'(1 << WORD_LG)) & buf_mask;
  assign chunk_mask = buf_mask[OFF_W-1:CHUNK_LG];
  assign hw_ptr_o   = off_q[OFF_W-1:CHUNK_LG];
  assign sw_m       = sw_ptr_i & chunk_mask;
  assign nxt_chunk  = (hw_ptr_o + PTR_W'(1)) & chunk_mask;
  // output drains up to sw pointer; input fills until one chunk short of it
  assign may_go_o   = dir_out_i ? (hw_ptr_o != sw_m) : (nxt_chunk != sw_m);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q  <= '0;
      frag_q <= 1'b0;
    end else begin
      frag_q <= step_i && !(start_i || clr_i) && ((off_nxt & frag_mask) == '0);
      if (start_i || clr_i) off_q <= '0;
      else if (step_i)      off_q <= off_nxt;
    end
  end

  assign off_o  = off_q;
  assign frag_o = frag_q;

  assert_frag_boundary_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frag_q |-> ((off_q & frag_mask) == '0));
endmodule

// File: rtl/audio_dma_xfer.sv
`timescale 1ns/1ps
module audio_dma_xfer
  import audio_dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              dir_out_i,
  input  logic              kill_i,
  input  logic              may_go_i,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] smp_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i,
  output logic              req_o,
  output logic              we_o,
  output logic              step_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] smp_o
);
  logic              req_q, buf_v;
  logic [DATA_W-1:0] buf_q, smp_q;
  logic              ack_ok;

  assign ack_ok = req_q && mem_ack_i;
  assign step_o = ack_ok && !kill_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      buf_v <= 1'b0;
      buf_q <= '0;
      smp_q <= '0;
    end else if (kill_i) begin
      req_q <= 1'b0;
      buf_v <= 1'b0;
      smp_q <= '0;
    end else if (en_i) begin
      if (dir_out_i) begin
        if (ack_ok) begin
          buf_q <= mem_rdata_i;
          buf_v <= 1'b1;
          req_q <= 1'b0;
        end else if (!req_q && !buf_v && may_go_i) begin
          req_q <= 1'b1;
        end
        // no staged word on a tick: smp_q holds (underflow repeat)
        if (tick_i && buf_v) begin
          smp_q <= buf_q;
          buf_v <= 1'b0;
        end
      end else begin
        if (ack_ok) begin
          buf_v <= 1'b0;
          req_q <= 1'b0;
        end else if (buf_v && !req_q) begin
          req_q <= 1'b1;
        end
        if (tick_i && !buf_v && may_go_i) begin
          buf_q <= smp_i;
          buf_v <= 1'b1;
        end
      end
    end
  end

  assign req_o   = req_q;
  assign we_o    = !dir_out_i;
  assign wdata_o = buf_q;
  assign smp_o   = smp_q;

  assert_idle_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (smp_q == '0));
  assert_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !mem_ack_i && !kill_i) |=> req_q);
  assert_fetch_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(req_q) && dir_out_i) |-> $past(may_go_i));
endmodule

// File: rtl/audio_ring_dma.sv
`timescale 1ns/1ps
module audio_ring_dma
  import audio_dma_pkg::*;
#(
  parameter int ADDR_W = BASE_W + 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       ctl_rd_o,
  output logic [2:0]        slot_o,
  output logic              stereo_o,
  output logic              wide_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i,
  input  logic              slot_tick_i,
  input  logic [DATA_W-1:0] smp_i,
  output logic [DATA_W-1:0] smp_o,
  output logic              frag_irq_o
);
  localparam int OFF_W = PTR_W + CHUNK_LG;

  logic [BASE_W-1:0] base;
  fmt_t              fmt;
  ctl_t              ctl;
  logic              start, stop, clr, kill, step, may_go;
  logic [OFF_W-1:0]  off;
  logic [PTR_W-1:0]  hw_ptr, sw_ptr, wfield, rfield;

  audio_dma_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .base_o(base), .fmt_o(fmt), .ctl_o(ctl),
    .start_o(start), .stop_o(stop), .clr_o(clr)
  );

  assign kill   = start || stop || clr;
  assign sw_ptr = fmt.dir_out ? ctl.wptr : ctl.rptr;

  audio_dma_ring u_ring (
    .clk_i, .rst_ni,
    .start_i(start), .clr_i(clr), .step_i(step),
    .dir_out_i(fmt.dir_out), .size_i(ctl.size), .tmask_i(ctl.tmask),
    .sw_ptr_i(sw_ptr), .off_o(off), .hw_ptr_o(hw_ptr),
    .may_go_o(may_go), .frag_o(frag_irq_o)
  );

  audio_dma_xfer u_xfer (
    .clk_i, .rst_ni,
    .en_i(ctl.en), .dir_out_i(fmt.dir_out), .kill_i(kill),
    .may_go_i(may_go), .tick_i(slot_tick_i), .smp_i(smp_i),
    .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i),
    .req_o(mem_req_o), .we_o(mem_we_o), .step_o(step),
    .wdata_o(mem_wdata_o), .smp_o(smp_o)
  );

  assign mem_addr_o = {base, 8'h00} + ADDR_W'(off);
  assign wfield     = fmt.dir_out ? ctl.wptr : hw_ptr;
  assign rfield     = fmt.dir_out ? hw_ptr : ctl.rptr;
  assign ctl_rd_o   = {8'h00, rfield, wfield, ctl.tmask, ctl.size, ctl.en, 1'b0};
  assign slot_o     = fmt.slot;
  assign stereo_o   = fmt.stereo;
  assign wide_o     = fmt.wide;

  assert_reset_bit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i == SEL_CTL && reg_wdata_i[0]) |=> (ctl_rd_o == '0 && !mem_req_o));
endmodule

// File: tb/audio_ring_dma_bench.sv
`timescale 1ns/1ps
module audio_ring_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] ctl_rd_o;
  logic [2:0]  slot_o;
  logic        stereo_o, wide_o, mem_req_o, mem_we_o, frag_irq_o;
  logic [39:0] mem_addr_o;
  logic [31:0] mem_wdata_o, smp_o;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        tick = 1'b0;
  logic [31:0] smp_in = '0;

  always #4 clk = ~clk;

  audio_ring_dma u_audio_ring_dma (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .ctl_rd_o, .slot_o, .stereo_o, .wide_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
    .slot_tick_i(tick), .smp_i(smp_in), .smp_o, .frag_irq_o
  );

  int          n_chk = 0, n_fail = 0;
  bit          done = 0;
  logic [31:0] base_exp = '0;
  int          off_exp = 0, buf_bytes = 256, words = 0, frag_cnt = 0;
  logic [31:0] pend = '0, exp_smp = '0;
  bit          pend_v = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctlw(bit rs, bit en, int s, int t, int wp, int rp);
    return {8'h00, 8'(rp), 8'(wp), 3'(t), 3'(s), en, rs};
  endfunction

  task automatic responder();
    forever begin
      @(negedge clk);
      if (frag_irq_o) frag_cnt++;
      if (mem_req_o && !mem_ack) begin
        logic [39:0] a;
        a = {base_exp, 8'h00} + 40'(off_exp);
        chk(mem_addr_o == a, "R2 address", mem_addr_o, a);
        chk(mem_addr_o[37] == base_exp[29], "R2 coherence bit", mem_addr_o[37], base_exp[29]);
        if (mem_we_o) begin
          chk(mem_wdata_o == 32'h1000 + 32'(words), "R12 write data", mem_wdata_o, 32'h1000 + words);
        end else begin
          mem_rdata = mem_addr_o[31:0] ^ 32'hC3C3_0000;
          pend = mem_rdata;
          pend_v = 1;
        end
        words++;
        off_exp = (off_exp + 4) % buf_bytes;
        mem_ack = 1'b1;
      end else begin
        mem_ack = 1'b0;
      end
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic do_tick(bit out_chk, logic [31:0] din);
    repeat (5) @(negedge clk);
    if (pend_v) begin exp_smp = pend; pend_v = 0; end
    smp_in = din; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    if (out_chk) chk(smp_o == exp_smp, "R10 sample on tick", smp_o, exp_smp);
  endtask

  task automatic run_ticks(int k);
    for (int i = 0; i < k; i++) do_tick(1'b1, '0);
  endtask

  task automatic prep(logic [31:0] b, int s, logic [31:0] fmt);
    base_exp = b;
    wr(2'd0, b);
    wr(2'd1, fmt);
    wr(2'd2, ctlw(1, 0, 0, 0, 0, 0));
    buf_bytes = 1 << (s + 6);
    off_exp = 0; words = 0; frag_cnt = 0; pend_v = 0; exp_smp = '0;
  endtask

  task automatic run_out(int s, int t, logic [31:0] b);
    int n, fb, fexp;
    n  = (1 << (s + 6)) / 32;
    fb = 1 << (13 - t);
    fexp = ((1 << (s + 6)) >= fb) ? (1 << (s + 6)) / fb : 1;
    prep(b, s, 32'h0000_0001);
    wr(2'd2, ctlw(0, 1, s, t, n - 1, 0));
    run_ticks((n - 1) * 8 + 2);
    chk(words == (n - 1) * 8, "R5 output stalls at sw pointer", words, (n - 1) * 8);
    chk(ctl_rd_o[23:16] == 8'(n - 1), "R4 hw read pointer", ctl_rd_o[23:16], n - 1);
    chk(ctl_rd_o[15:8] == 8'(n - 1), "R4 sw write pointer", ctl_rd_o[15:8], n - 1);
    chk(mem_req_o == 1'b0, "R5 no request when stalled", mem_req_o, 0);
    wr(2'd2, ctlw(0, 1, s, t, 0, 0));
    run_ticks(10);
    chk(words == n * 8, "R3 words over full ring", words, n * 8);
    chk(ctl_rd_o[23:16] == 8'h00, "R3 pointer wrapped", ctl_rd_o[23:16], 0);
    chk(frag_cnt == fexp, "R6 fragment pulses", frag_cnt, fexp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fork responder(); join_none
    @(negedge clk);
    chk(ctl_rd_o == '0, "R1 control readback", ctl_rd_o, 0);
    chk(mem_req_o == 1'b0, "R1 request", mem_req_o, 0);
    chk(smp_o == '0, "R1 sample", smp_o, 0);
    chk(frag_irq_o == 1'b0, "R1 interrupt", frag_irq_o, 0);

    wr(2'd1, {26'b0, 3'd5, 1'b0, 1'b1, 1'b1});
    chk(stereo_o == 1'b1 && wide_o == 1'b0 && slot_o == 3'd5, "R13 format a",
        {stereo_o, wide_o, slot_o}, {1'b1, 1'b0, 3'd5});
    wr(2'd1, {26'b0, 3'd2, 1'b1, 1'b0, 1'b0});
    chk(stereo_o == 1'b0 && wide_o == 1'b1 && slot_o == 3'd2, "R13 format b",
        {stereo_o, wide_o, slot_o}, {1'b0, 1'b1, 3'd2});

    for (int s = 2; s <= 3; s++)
      for (int t = 3; t <= 7; t += 2)
        run_out(s, t, 32'h2000_0000 | 32'((s * 16 + t) << 4));

    // R9, R11, R7, R8 sequence on a 256-byte output ring
    prep(32'h0001_2300, 2, 32'h0000_0001);
    wr(2'd2, ctlw(0, 1, 2, 7, 2, 0));
    run_ticks(18);
    chk(ctl_rd_o[23:16] == 8'd2, "R9 pointer before stop", ctl_rd_o[23:16], 2);
    chk(smp_o != '0, "R11 playing before stop", smp_o, 1);
    pend_v = 0; exp_smp = '0;
    wr(2'd2, ctlw(0, 0, 2, 7, 2, 0));
    chk(ctl_rd_o[23:16] == 8'd2, "R9 pointer kept on plain stop", ctl_rd_o[23:16], 2);
    chk(smp_o == '0, "R11 zero after stop", smp_o, 0);
    do_tick(1'b1, '0);
    chk(smp_o == '0, "R11 zero on idle tick", smp_o, 0);
    chk(mem_req_o == 1'b0, "R11 no request while idle", mem_req_o, 0);
    off_exp = 0; words = 0;
    wr(2'd2, ctlw(0, 1, 2, 7, 1, 0));
    chk(ctl_rd_o[23:16] == 8'd0, "R7 restart at offset 0", ctl_rd_o[23:16], 0);
    run_ticks(10);
    chk(words == 8, "R7 words after restart", words, 8);
    chk(ctl_rd_o[23:16] == 8'd1, "R7 pointer after restart", ctl_rd_o[23:16], 1);
    pend_v = 0; exp_smp = '0;
    wr(2'd2, ctlw(0, 0, 2, 7, 0, 0));
    chk(ctl_rd_o[23:16] == 8'd0, "R9 pointer zeroed", ctl_rd_o[23:16], 0);
    off_exp = 0; words = 0;
    wr(2'd2, ctlw(0, 1, 3, 5, 3, 0));
    repeat (3) @(negedge clk);
    wr(2'd2, ctlw(1, 0, 0, 0, 0, 0));
    pend_v = 0; exp_smp = '0;
    chk(ctl_rd_o == '0, "R8 control cleared", ctl_rd_o, 0);
    repeat (4) @(negedge clk);
    chk(mem_req_o == 1'b0, "R8 no request after reset bit", mem_req_o, 0);
    chk(smp_o == '0, "R8 sample cleared", smp_o, 0);

    // input channel: rptr 2 limits hardware to chunk 0
    prep(32'h0004_5600, 2, 32'h0000_0000);
    wr(2'd2, ctlw(0, 1, 2, 7, 0, 2));
    for (int k = 0; k < 12; k++) do_tick(1'b0, 32'h1000 + 32'(k));
    repeat (5) @(negedge clk);
    chk(words == 8, "R5 input stalls before sw pointer", words, 8);
    chk(ctl_rd_o[15:8] == 8'd1, "R4 hw write pointer on input", ctl_rd_o[15:8], 1);
    chk(ctl_rd_o[23:16] == 8'd2, "R4 sw read pointer on input", ctl_rd_o[23:16], 2);
    chk(smp_o == '0, "R12 input leaves smp_o idle", smp_o, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule